// File: doc/BRIEF.md
# Host-Port Remote Memory Read Engine

This block sits on the slave side of a host bus. It lets an external master fetch one word from the slave's local data memory without any software running on the slave. The master writes a memory address under one dedicated function code. That single write loads the transmit register and raises a busy flag. A small sequencer then moves the address into an internal pointer, reads the local memory through a synchronous port, and parks the word in a host-readable receive register. When the word is ready, the sequencer drops the busy flag.

The master polls a side-effect-free status register until the busy flag reads 0, and then reads the receive register. A bank of semaphore bits supports an atomic test-and-set. The access that sets a bit returns that bit's earlier value, so competing masters can tell who won.

A host access counts only when the strobe `hb_cs_n` is low and the attribute line `hb_attr` is high. The 4-bit function field `hb_fn` selects the register.

Top module: `hpmr_engine`

## Requirements
- R1: After reset the status word reads TXDE=1, HMRC=0 and ERR=0. The receive register reads 0 and every semaphore bit reads 0. Status bit positions: bit 0 = TXDE (transmit empty), bit 1 = HMRC (read pending), bit 2 = ERR (sticky overrun). All other status bits read 0.
- R2: An access is decoded only while `hb_cs_n`=0 and `hb_attr`=1. With either line inactive, or with a function code that is not listed, a write changes no state and a read returns 0. Function codes: 0x0 = status read, 0x1 = receive read, 0x3 = address write plus memory read request, 0x4 = semaphore test-and-set write, 0x5 = semaphore clear write, 0x6 = semaphore read.
- R3: A request write (code 0x3) accepted while HMRC=0 has two effects at that clock edge: TXDE goes to 0 and HMRC goes to 1. TXDE returns to 1 at the next edge, once the address has been taken.
- R4: For each accepted request, `mem_rd_en` is high for exactly one cycle, in the second cycle after the accepting edge. During that cycle `mem_addr` equals the low AW bits of the written word. `mem_rdata` is taken one cycle later.
- R5: HMRC clears at the fourth clock edge after the accepting edge. A poller therefore sees HMRC=1 on exactly four consecutive status reads. The receive register changes only at that same edge.
- R6: A request write that arrives while HMRC=1 is ignored. The fetch already in progress completes unchanged, and ERR is set and stays set until reset.
- R7: Status reads have no side effects, so repeated polling leaves every flag unchanged.
- R8: A test-and-set write (code 0x4) names a bit by the low bits of `hb_wdata`. During that same access `hb_rdata` returns the bit's previous value in bit 0, and the bit reads 1 afterwards.
- R9: A clear write (code 0x5) zeroes the indexed semaphore bit. A semaphore read (code 0x6) returns all semaphore bits, with bit n in position n.
- R10: A receive read (code 0x1) returns the word last delivered by the sequencer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_cs_n | input | 1 | Host strobe, active low |
| hb_attr | input | 1 | Host attribute line, must be 1 for a decoded access |
| hb_we | input | 1 | 1 = write, 0 = read |
| hb_fn | input | 4 | Function/register select |
| hb_wdata | input | DW | Host write data |
| hb_rdata | output | DW | Host read data (combinational) |
| mem_rd_en | output | 1 | Local memory read strobe |
| mem_addr | output | AW | Local memory address |
| mem_rdata | input | DW | Local memory data, valid one cycle after the strobe |

## Verification
The embedded properties check, on every cycle, the local timing relations:
- an accepted request raises HMRC and lowers TXDE at the next edge;
- TXDE recovers after one cycle;
- the memory strobe is a single-cycle pulse that occurs only while a fetch is pending;
- HMRC falls only after four cycles high;
- the receive register moves only when HMRC falls;
- a request during a busy period raises the sticky error bit;
- semaphore set and clear take effect at the next edge.

Only the bench scenarios can show the data path end to end. They show that the word delivered for a given address is the one memory holds there, including the lowest and highest addresses. They also show that an overrun request leaves the first fetch intact, that test-and-set returns the earlier bit value when masters compete, and that accesses with the wrong strobe, attribute or function code leave no trace.

// File: rtl/hpmr_pkg.sv
package hpmr_pkg;

   // host function codes (field hb_fn)
   localparam logic [3:0] FN_STAT  = 4'h0;
   localparam logic [3:0] FN_RX    = 4'h1;
   localparam logic [3:0] FN_REQ   = 4'h3;
   localparam logic [3:0] FN_TAS   = 4'h4;
   localparam logic [3:0] FN_CLR   = 4'h5;
   localparam logic [3:0] FN_SEMRD = 4'h6;

   // status word bit positions
   localparam int ST_TXDE = 0;
   localparam int ST_HMRC = 1;
   localparam int ST_ERR  = 2;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_ADDR  = 3'd1,
      SQ_FETCH = 3'd2,
      SQ_LOAD  = 3'd3,
      SQ_XFER  = 3'd4
   } seq_state_t;

   typedef struct packed {
      logic req;
      logic tas;
      logic clr;
      logic rd_stat;
      logic rd_rx;
      logic rd_sem;
   } hb_dec_t;

endpackage

// File: rtl/hpmr_decode.sv
module hpmr_decode
   import hpmr_pkg::*;
(
   input  logic       cs_n,
   input  logic       attr,
   input  logic       we,
   input  logic [3:0] fn,
   output hb_dec_t    dec
);

   logic acc;

   always_comb begin
      acc         = !cs_n && attr;
      dec.req     = acc &&  we && (fn == FN_REQ);
      dec.tas     = acc &&  we && (fn == FN_TAS);
      dec.clr     = acc &&  we && (fn == FN_CLR);
      dec.rd_stat = acc && !we && (fn == FN_STAT);
      dec.rd_rx   = acc && !we && (fn == FN_RX);
      dec.rd_sem  = acc && !we && (fn == FN_SEMRD);
   end

endmodule

// File: rtl/hpmr_seq.sv
module hpmr_seq
   import hpmr_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [DW-1:0] wdata,
   output logic          txde,
   output logic          hmrc,
   output logic          err,
   output logic [DW-1:0] rx,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata
);

   seq_state_t    state;
   logic [DW-1:0] tx_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] hold_q;
   logic          unused_tx_hi;

   assign unused_tx_hi = ^tx_q[DW-1:AW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         tx_q   <= '0;
         addr_q <= '0;
         hold_q <= '0;
         rx     <= '0;
         txde   <= 1'b1;
         hmrc   <= 1'b0;
         err    <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (req) begin
                  tx_q  <= wdata;
                  txde  <= 1'b0;
                  hmrc  <= 1'b1;
                  state <= SQ_ADDR;
               end
            end
            SQ_ADDR: begin
               addr_q <= tx_q[AW-1:0];
               txde   <= 1'b1;
               state  <= SQ_FETCH;
            end
            SQ_FETCH: state <= SQ_LOAD;
            SQ_LOAD: begin
               hold_q <= mem_rdata;
               state  <= SQ_XFER;
            end
            SQ_XFER: begin
               rx    <= hold_q;
               hmrc  <= 1'b0;
               state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
         if (req && hmrc) err <= 1'b1;
      end
   end

   assign mem_rd_en = (state == SQ_FETCH);
   assign mem_addr  = addr_q;

   // R3: accepted request flips both flags at the next edge
   p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !hmrc) |=> (hmrc && !txde));
   // R3: transmit-empty recovers after one cycle
   p_txde_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txde) |=> txde);
   // R4: memory strobe only while pending, single cycle
   p_memrd_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (hmrc && txde));
   p_memrd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);
   // R5: pending flag held four cycles before clearing
   p_clear_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hmrc) |-> ($past(hmrc, 2) && $past(hmrc, 3) && $past(hmrc, 4)));
   // R5: receive register moves only as pending clears
   p_rx_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx) |-> $fell(hmrc));
   // R6: overrun raises sticky error
   p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && hmrc) |=> err);
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

endmodule

// File: rtl/hpmr_sem.sv
module hpmr_sem #(
   parameter int SEMN = 8,
   localparam int SIW = $clog2(SEMN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tas,
   input  logic            clr,
   input  logic [SIW-1:0]  idx,
   output logic [SEMN-1:0] sem,
   output logic            prev
);

   for (genvar b = 0; b < SEMN; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sem[b] <= 1'b0;
         else if (tas && (idx == SIW'(b)))
            sem[b] <= 1'b1;
         else if (clr && (idx == SIW'(b)))
            sem[b] <= 1'b0;
      end
   end

   assign prev = sem[idx];

   // R8: test-and-set leaves the bit set
   p_tas_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tas |=> sem[$past(idx)]);
   // R9: clear leaves the bit cleared
   p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !tas) |=> !sem[$past(idx)]);

endmodule

// File: rtl/hpmr_engine.sv
module hpmr_engine
   import hpmr_pkg::*;
#(
   parameter int DW   = 32,
   parameter int AW   = 10,
   parameter int SEMN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hb_cs_n,
   input  logic          hb_attr,
   input  logic          hb_we,
   input  logic [3:0]    hb_fn,
   input  logic [DW-1:0] hb_wdata,
   output logic [DW-1:0] hb_rdata,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata
);

   localparam int SIW = $clog2(SEMN);

   if (AW < 1 || AW >= DW) begin : g_chk_aw
      $error("hpmr_engine: AW must be in 1..DW-1");
   end
   if (SEMN < 2 || SEMN > DW || (1 << SIW) != SEMN) begin : g_chk_sem
      $error("hpmr_engine: SEMN must be a power of two in 2..DW");
   end
   if (DW < 3) begin : g_chk_dw
      $error("hpmr_engine: DW too small for status word");
   end

   hb_dec_t         dec;
   logic            txde, hmrc, err;
   logic [DW-1:0]   rx;
   logic [SEMN-1:0] sem;
   logic            sem_prev;

   hpmr_decode u_dec (
      .cs_n (hb_cs_n),
      .attr (hb_attr),
      .we   (hb_we),
      .fn   (hb_fn),
      .dec  (dec)
   );

   hpmr_seq #(.DW(DW), .AW(AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (dec.req),
      .wdata     (hb_wdata),
      .txde      (txde),
      .hmrc      (hmrc),
      .err       (err),
      .rx        (rx),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata)
   );

   hpmr_sem #(.SEMN(SEMN)) u_sem (
      .clk   (clk),
      .rst_n (rst_n),
      .tas   (dec.tas),
      .clr   (dec.clr),
      .idx   (hb_wdata[SIW-1:0]),
      .sem   (sem),
      .prev  (sem_prev)
   );

   always_comb begin
      hb_rdata = '0;
      if (dec.rd_stat) begin
         hb_rdata[ST_TXDE] = txde;
         hb_rdata[ST_HMRC] = hmrc;
         hb_rdata[ST_ERR]  = err;
      end else if (dec.rd_rx) begin
         hb_rdata = rx;
      end else if (dec.rd_sem) begin
         hb_rdata = DW'(sem);
      end else if (dec.tas) begin
         hb_rdata[0] = sem_prev;
      end
   end

   // R7: a status read never disturbs the flags
   p_poll_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.rd_stat && !hmrc) |=> ($stable(txde) && $stable(err) && !hmrc));
   // R2: strobe inactive means no request reaches the sequencer
   p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_cs_n || !hb_attr) |-> !(dec.req || dec.tas || dec.clr));

endmodule

// File: tb/sim_hpmr_engine.sv
module sim_hpmr_engine;

   localparam int DW = 32;
   localparam int AW = 10;
   localparam int SEMN = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hb_cs_n = 1'b1;
   logic          hb_attr = 1'b0;
   logic          hb_we = 1'b0;
   logic [3:0]    hb_fn = 4'h0;
   logic [DW-1:0] hb_wdata = '0;
   logic [DW-1:0] hb_rdata;
   logic          mem_rd_en;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   hpmr_engine #(.DW(DW), .AW(AW), .SEMN(SEMN)) u0 (.*);

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return (DW'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   always @(posedge clk)
      if (mem_rd_en) mem_rdata <= memf(mem_addr);

   // behavioural reference
   bit            m_txde = 1, m_hmrc = 0, m_err = 0;
   logic [DW-1:0] m_rx = '0;
   logic [AW-1:0] m_addr = '0;
   bit   [SEMN-1:0] m_sem = '0;
   int            m_age = -1;
   logic [DW-1:0] last_rd;

   function automatic logic [DW-1:0] exp_rd(input logic cs_n, attr, we,
                                            input logic [3:0] fn,
                                            input logic [DW-1:0] wd);
      logic [DW-1:0] r = '0;
      if (!cs_n && attr) begin
         if (!we && fn == 4'h0) r = DW'({m_err, m_hmrc, m_txde});
         else if (!we && fn == 4'h1) r = m_rx;
         else if (!we && fn == 4'h6) r = DW'(m_sem);
         else if (we && fn == 4'h4) r = DW'(m_sem[wd[2:0]]);
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic cs_n, attr, we, input logic [3:0] fn,
                      input logic [DW-1:0] wd, input string tag);
      logic [DW-1:0] er;
      bit            een, acc, pre_h;
      @(negedge clk);
      hb_cs_n = cs_n; hb_attr = attr; hb_we = we; hb_fn = fn; hb_wdata = wd;
      #1;
      er  = exp_rd(cs_n, attr, we, fn, wd);
      een = (m_age == 1);
      last_rd = hb_rdata;
      check(hb_rdata === er, tag, hb_rdata, er);
      check(mem_rd_en === een && (!een || mem_addr === m_addr), "R4",
            {mem_rd_en, 21'b0, mem_addr}, {een, 21'b0, m_addr});
      @(posedge clk);
      acc = !cs_n && attr;
      pre_h = m_hmrc;
      if (m_age >= 0) begin
         m_age++;
         if (m_age == 1) m_txde = 1;
         if (m_age == 4) begin m_rx = memf(m_addr); m_hmrc = 0; m_age = -1; end
      end
      if (acc && we && fn == 4'h3) begin
         if (pre_h) m_err = 1;
         else begin m_addr = wd[AW-1:0]; m_hmrc = 1; m_txde = 0; m_age = 0; end
      end
      if (acc && we && fn == 4'h4) m_sem[wd[2:0]] = 1;
      if (acc && we && fn == 4'h5) m_sem[wd[2:0]] = 0;
   endtask

   task automatic rd(input logic [3:0] fn, input string tag);
      cyc(1'b0, 1'b1, 1'b0, fn, '0, tag);
   endtask
   task automatic wr(input logic [3:0] fn, input logic [DW-1:0] wd, input string tag);
      cyc(1'b0, 1'b1, 1'b1, fn, wd, tag);
   endtask
   task automatic idle(input string tag);
      cyc(1'b1, 1'b0, 1'b0, 4'h0, '0, tag);
   endtask

   // R5: count polls that see HMRC=1 after a request
   task automatic fetch(input logic [AW-1:0] a);
      int busy = 0;
      wr(4'h3, DW'(a), "R3");
      for (int i = 0; i < 8; i++) begin
         rd(4'h0, "R7");
         if (last_rd[1]) busy++;
      end
      check(busy == 4, "R5 busy polls", DW'(busy), 32'd4);
      rd(4'h1, "R10");
      check(last_rd === memf(a), "R10 data", last_rd, memf(a));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state
      rd(4'h0, "R1");
      check(last_rd === 32'h1, "R1 status", last_rd, 32'h1);
      rd(4'h1, "R1");
      rd(4'h6, "R1");
      // R2: undecoded accesses leave no trace
      cyc(1'b0, 1'b0, 1'b1, 4'h3, 32'h55, "R2");
      cyc(1'b1, 1'b1, 1'b1, 4'h3, 32'h55, "R2");
      cyc(1'b1, 1'b1, 1'b1, 4'h4, 32'h2, "R2");
      wr(4'h2, 32'h77, "R2");
      wr(4'h7, 32'h1, "R2");
      rd(4'h0, "R2");
      check(last_rd === 32'h1, "R2 status", last_rd, 32'h1);
      rd(4'h6, "R2");
      check(last_rd === 32'h0, "R2 sem", last_rd, 32'h0);
      // R3/R4/R5/R10: single fetches, edge addresses
      fetch(10'h012);
      fetch(10'h000);
      fetch(10'h3FF);
      for (int k = 0; k < 5; k++) fetch(AW'(k * 97 + 3));
      // R7: repeated polling while idle
      for (int k = 0; k < 4; k++) rd(4'h0, "R7");
      check(last_rd === 32'h1, "R7 stable", last_rd, 32'h1);
      // R6: overrun on the next cycle and on the clearing cycle
      wr(4'h3, 32'h21, "R3");
      wr(4'h3, 32'h99, "R6");
      rd(4'h0, "R6");
      check(last_rd[2] === 1'b1, "R6 err", last_rd, 32'h4);
      idle("R6");
      wr(4'h3, 32'h44, "R6");
      idle("R6");
      rd(4'h1, "R6");
      check(last_rd === memf(10'h21), "R6 first kept", last_rd, memf(10'h21));
      rd(4'h0, "R6");
      check(last_rd === 32'h5, "R6 sticky", last_rd, 32'h5);
      // R8/R9: semaphores
      wr(4'h4, 32'h3, "R8");
      check(last_rd === 32'h0, "R8 first win", last_rd, 32'h0);
      wr(4'h4, 32'h3, "R8");
      check(last_rd === 32'h1, "R8 lost", last_rd, 32'h1);
      wr(4'h4, 32'h7, "R8");
      rd(4'h6, "R9");
      check(last_rd === 32'h88, "R9 read", last_rd, 32'h88);
      wr(4'h5, 32'h3, "R9");
      rd(4'h6, "R9");
      check(last_rd === 32'h80, "R9 cleared", last_rd, 32'h80);
      wr(4'h4, 32'h3, "R8");
      check(last_rd === 32'h0, "R8 retake", last_rd, 32'h0);
      wr(4'h4, 32'h0, "R8");
      rd(4'h6, "R9");
      repeat (3) idle("R7");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule